// File: doc/BRIEF.md
# I2C Register-Table Loader

This block programs a peripheral on an I2C bus by writing a constant image of sixteen byte-wide registers into it. After a start pulse it issues one single-byte register write per register through the command port of an I2C master. Each command names the device address, the register index and the data byte. The loader then waits for that master to report the end of the transaction before it issues the next one. The bus timing itself belongs to the master.

Two images are held as elaboration-time parameters. A mode bit, sampled when the start is accepted, chooses which image is sent. The first transaction that ends without an acknowledge stops the sequence at once, and the index of that register is reported. A clean run ends with a one-cycle done pulse.

Top module: `i2c_table_loader`

## Requirements
- R1: After reset, busy_o, done_o, error_o and cmd_valid_o are 0, and fail_idx_o is 0.
- R2: A start_i pulse sampled while idle raises busy_o on the next cycle. In that same cycle, cmd_valid_o is high with cmd_reg_o equal to 0.
- R3: Registers are written in ascending index order, 0 up to NREG-1. Each command is a single cycle of cmd_valid_o carrying cmd_dev_o = DEV_ADDR, cmd_reg_o = the index zero-extended to 8 bits, and the data byte. After a positively acknowledged xfer_done_i, the next command appears exactly one cycle later.
- R4: The data byte for index i is bits [8i+7:8i] of IMG0 when the mode sampled at start was 0, and of IMG1 when it was 1. Changing mode_i while busy has no effect on the bytes sent.
- R5: When the transaction for index NREG-1 completes with an acknowledge, done_o pulses one cycle later. In that same cycle busy_o is 0.
- R6: An xfer_done_i with xfer_nack_i high causes several things. error_o pulses on the next cycle, with busy_o 0 in that cycle. fail_idx_o takes the index of the failed register. No further command is issued. fail_idx_o holds this value until the next accepted start, which clears it to 0.
- R7: A start_i pulse while busy_o is high is ignored: the sequence, its index and its image continue unchanged.
- R8: done_o and error_o are each high for at most one cycle per run and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, honoured only while idle |
| mode_i | input | 1 | Image select (0 or 1), sampled at start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: all registers written |
| error_o | output | 1 | One-cycle pulse: a write was not acknowledged |
| fail_idx_o | output | IDX_W | Index of the register that failed |
| cmd_valid_o | output | 1 | One-cycle command strobe to the I2C master |
| cmd_dev_o | output | 7 | 7-bit device address |
| cmd_reg_o | output | 8 | Register index byte |
| cmd_data_o | output | 8 | Register data byte |
| xfer_done_i | input | 1 | Master reports end of transaction |
| xfer_nack_i | input | 1 | Qualifies xfer_done_i: no acknowledge seen |

## Verification
Every result of this block is due a fixed number of cycles after its cause:
- The first command appears one cycle after the start is sampled.
- Each following command appears one cycle after the acknowledged completion of the previous one.
- done_o or error_o appears one cycle after the final completion.

The bench's responder records the falling edge on which it drives each completion, and checks that the next command or end pulse is seen on the very next falling edge. End pulses are checked again one edge later to confirm they have dropped. The command count and fail_idx_o are checked after a quiet window that follows each run.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    localparam int BYTE_W = 8;
    localparam int DEV_W  = 7;

    typedef enum logic [1:0] {
        LST_IDLE  = 2'd0,
        LST_ISSUE = 2'd1,
        LST_WAIT  = 2'd2
    } ldr_state_e;
endpackage

// File: rtl/ldr_table.sv
module ldr_table #(
    parameter int                        NREG  = 16,
    parameter int                        IDX_W = 4,
    parameter logic [NREG*ldr_pkg::BYTE_W-1:0] IMG0 = '0,
    parameter logic [NREG*ldr_pkg::BYTE_W-1:0] IMG1 = '0
) (
    input  logic                       sel_i,
    input  logic [IDX_W-1:0]           idx_i,
    output logic [ldr_pkg::BYTE_W-1:0] data_o
);
    localparam int BW = ldr_pkg::BYTE_W;

    logic [BW-1:0] img [2][NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        assign img[0][i] = IMG0[i*BW +: BW];
        assign img[1][i] = IMG1[i*BW +: BW];
    end

    assign data_o = img[sel_i][idx_i];
endmodule

// File: rtl/ldr_fsm.sv
module ldr_fsm #(
    parameter int NREG  = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             xfer_done_i,
    input  logic             xfer_nack_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o,
    output logic             issue_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             mode_o,
    output logic [IDX_W-1:0] fail_idx_o
);
    import ldr_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NREG - 1);

    typedef struct packed {
        ldr_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             mode;
        logic             done;
        logic             err;
        logic [IDX_W-1:0] fidx;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            LST_IDLE: begin
                if (start_i) begin
                    r_d.st   = LST_ISSUE;
                    r_d.idx  = '0;
                    r_d.mode = mode_i;
                    r_d.fidx = '0;
                end
            end
            LST_ISSUE: r_d.st = LST_WAIT;
            LST_WAIT: begin
                if (xfer_done_i) begin
                    if (xfer_nack_i) begin
                        r_d.st   = LST_IDLE;
                        r_d.err  = 1'b1;
                        r_d.fidx = r_q.idx;
                    end else if (r_q.idx == LAST) begin
                        r_d.st   = LST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = LST_ISSUE;
                    end
                end
            end
            default: r_d.st = LST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: LST_IDLE, idx: '0, mode: 1'b0, done: 1'b0, err: 1'b0, fidx: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != LST_IDLE);
    assign issue_o    = (r_q.st == LST_ISSUE);
    assign done_o     = r_q.done;
    assign error_o    = r_q.err;
    assign idx_o      = r_q.idx;
    assign mode_o     = r_q.mode;
    assign fail_idx_o = r_q.fidx;

    AST_FIRST_CMD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (issue_o && idx_o == '0)); // R2
    AST_NEXT_CMD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !issue_o && xfer_done_i && !xfer_nack_i && idx_o != LAST)
        |=> (issue_o && idx_o == $past(idx_o) + 1'b1)); // R3
    AST_IMAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(mode_o)); // R4
    AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !issue_o && xfer_done_i && !xfer_nack_i && idx_o == LAST)
        |=> (done_o && !busy_o)); // R5
    AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !issue_o && xfer_done_i && xfer_nack_i)
        |=> (error_o && !busy_o && fail_idx_o == $past(idx_o))); // R6
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !issue_o && !xfer_done_i) |=> (busy_o && $stable(idx_o))); // R7
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o)); // R8
    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |=> !(done_o || error_o)); // R8
endmodule

// File: rtl/i2c_table_loader.sv
module i2c_table_loader #(
    parameter int                          NREG     = 16,
    parameter logic [ldr_pkg::DEV_W-1:0]   DEV_ADDR = 7'h58,
    parameter logic [NREG*ldr_pkg::BYTE_W-1:0] IMG0 = {NREG{8'h5A}},
    parameter logic [NREG*ldr_pkg::BYTE_W-1:0] IMG1 = {NREG{8'hA5}},
    localparam int                         IDX_W    = $clog2(NREG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       mode_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic                       error_o,
    output logic [IDX_W-1:0]           fail_idx_o,
    output logic                       cmd_valid_o,
    output logic [ldr_pkg::DEV_W-1:0]  cmd_dev_o,
    output logic [ldr_pkg::BYTE_W-1:0] cmd_reg_o,
    output logic [ldr_pkg::BYTE_W-1:0] cmd_data_o,
    input  logic                       xfer_done_i,
    input  logic                       xfer_nack_i
);
    logic [IDX_W-1:0] idx;
    logic             img_sel;

    ldr_fsm #(.NREG(NREG), .IDX_W(IDX_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .xfer_done_i(xfer_done_i),
        .xfer_nack_i(xfer_nack_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .error_o    (error_o),
        .issue_o    (cmd_valid_o),
        .idx_o      (idx),
        .mode_o     (img_sel),
        .fail_idx_o (fail_idx_o)
    );

    ldr_table #(.NREG(NREG), .IDX_W(IDX_W), .IMG0(IMG0), .IMG1(IMG1)) u_table (
        .sel_i (img_sel),
        .idx_i (idx),
        .data_o(cmd_data_o)
    );

    assign cmd_dev_o = DEV_ADDR;
    assign cmd_reg_o = ldr_pkg::BYTE_W'(idx);

    AST_CMD_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> busy_o); // R3
    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o); // R3
endmodule

// File: tb/sim_i2c_table_loader.sv
module sim_i2c_table_loader;
    localparam int NREG = 16;
    localparam int IDX_W = 4;
    localparam logic [6:0] DEV = 7'h2B;

    function automatic logic [7:0] exp_byte(input logic m, input int i);
        return m ? 8'(8'h3C + 7 * i) : 8'(8'hC1 ^ (13 * i));
    endfunction

    function automatic logic [NREG*8-1:0] mk_img(input logic m);
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_byte(m, i);
        return v;
    endfunction

    localparam logic [NREG*8-1:0] T0 = mk_img(1'b0);
    localparam logic [NREG*8-1:0] T1 = mk_img(1'b1);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
    logic xfer_done = 1'b0, xfer_nack = 1'b0;
    logic busy, done, error, cmd_valid;
    logic [IDX_W-1:0] fail_idx;
    logic [6:0] cmd_dev;
    logic [7:0] cmd_reg, cmd_data;

    always #4 clk = ~clk;

    i2c_table_loader #(.NREG(NREG), .DEV_ADDR(DEV), .IMG0(T0), .IMG1(T1)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .busy_o(busy), .done_o(done), .error_o(error), .fail_idx_o(fail_idx),
        .cmd_valid_o(cmd_valid), .cmd_dev_o(cmd_dev), .cmd_reg_o(cmd_reg),
        .cmd_data_o(cmd_data), .xfer_done_i(xfer_done), .xfer_nack_i(xfer_nack)
    );

    int checks = 0, errors = 0;
    int cyc = 0, n_cmds = 0, due = -1, cd = 0, last_resp = -1;
    int nack_at = 99, resp_lat = 1;
    logic run_mode = 1'b0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Responder standing in for the I2C master
    always @(negedge clk) begin
        cyc++;
        xfer_done = 1'b0;
        xfer_nack = 1'b0;
        if (rst_n && cmd_valid) begin
            chk(cmd_dev == DEV, "R3 dev", int'(cmd_dev), int'(DEV));
            chk(int'(cmd_reg) == n_cmds, "R3 reg order", int'(cmd_reg), n_cmds);
            chk(cmd_data == exp_byte(run_mode, n_cmds), "R4 data",
                int'(cmd_data), int'(exp_byte(run_mode, n_cmds)));
            if (due >= 0) chk(cyc == due, "R3 cmd timing", cyc, due);
            due = -1;
            n_cmds++;
            cd = resp_lat;
        end else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                xfer_done = 1'b1;
                xfer_nack = (n_cmds - 1 == nack_at);
                last_resp = cyc;
                if (!xfer_nack && n_cmds < NREG) due = cyc + 1;
            end
        end
    end

    task automatic run(input logic m, input int nk, input int lat);
        int exp_cmds, guard;
        run_mode = m; nack_at = nk; resp_lat = lat; n_cmds = 0; due = -1;
        @(negedge clk); start = 1'b1; mode = m;
        @(negedge clk); #1;
        start = 1'b0; mode = ~m;               // R4: mode change while busy
        chk(busy && cmd_valid && cmd_reg == 8'd0, "R2 first cmd", int'(busy), 1);
        chk(fail_idx == '0, "R6 fail_idx cleared", int'(fail_idx), 0);
        @(negedge clk); #1;
        start = 1'b1;                          // R7: start while busy
        @(negedge clk); #1;
        start = 1'b0;
        guard = 0;
        while (!(done || error) && guard < 400) begin
            @(negedge clk); #1; guard++;
        end
        chk(cyc == last_resp + 1, "R5/R6 end timing", cyc, last_resp + 1);
        chk(done == (nk >= NREG), "R5 done", int'(done), int'(nk >= NREG));
        chk(error == (nk < NREG), "R6 error", int'(error), int'(nk < NREG));
        chk(!(done && error) && !busy, "R8 exclusive, busy low", int'(busy), 0);
        if (nk < NREG) chk(int'(fail_idx) == nk, "R6 fail_idx", int'(fail_idx), nk);
        @(negedge clk); #1;
        chk(!done && !error, "R8 one cycle", int'(done | error), 0);
        repeat (6) @(negedge clk);
        #1;
        exp_cmds = (nk < NREG) ? nk + 1 : NREG;
        chk(n_cmds == exp_cmds, "R6/R7 command count", n_cmds, exp_cmds);
        chk(!busy, "R7 stray start not accepted", int'(busy), 0);
        if (nk < NREG) chk(int'(fail_idx) == nk, "R6 fail_idx held", int'(fail_idx), nk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!busy && !done && !error && !cmd_valid && fail_idx == '0, "R1 reset",
            int'({busy, done, error, cmd_valid}), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) run(m[0], 99, 1 + m);
        for (int m = 0; m < 2; m++)
            for (int k = 0; k < NREG; k++) run(m[0], k, (k % 3) + 1);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule